// File: doc/BRIEF.md
# Accumulator Readout Scaler with Rounding

This block sits on the path from a 56-bit accumulator to a 24-bit data bus. The accumulator is an 8-bit extension above a 24-bit high word and a 24-bit low word. A two-bit scale mode selects one of three readouts: plain, a one-bit arithmetic right shift, or a one-bit arithmetic left shift. The block can then round to nearest at the bit just below the chosen output window. Last, it limits the result to the signed 24-bit range. The stored accumulator is never written. Only the word that leaves on the bus is scaled.

The block also reports the rounding bit position for the current mode, so the multiply-accumulate path can round at the same place. The fourth mode code is reserved. The block flags it and reads out as in plain mode. All outputs are registered, one clock after the inputs are presented.

Top module: `acc_scaler`

## Requirements
- R1: Mode 2'b00 (plain) outputs accumulator bits [47:24], with the rounding bit at position 23 reported on `rnd_pos_o`.
- R2: Mode 2'b01 (scale down) outputs bits [48:25], an arithmetic right shift by one, with the rounding bit at position 24.
- R3: Mode 2'b10 (scale up) outputs bits [46:23], an arithmetic left shift by one, with the rounding bit at position 22.
- R4: Mode 2'b11 raises `rsvd_o` and otherwise gives exactly the plain-mode results, including rounding position 23. The other modes hold `rsvd_o` low.
- R5: With `round_en_i` low the window is truncated, so the result rounds toward minus infinity. With it high, one is added at the rounding bit before truncation, which is round-half-up.
- R6: A result above 0x7FFFFF is output as 0x7FFFFF with `limit_o` high.
- R7: A result below the signed minimum is output as 0x800000 with `limit_o` high. `limit_o` is low whenever the result fits.
- R8: In scale-up mode, a value whose sign would change under the left shift counts as out of range and is limited according to the accumulator sign.
- R9: A carry out of the rounding addition that pushes the result out of range is limited like any other overflow.
- R10: Outputs are registered with one cycle of latency. A synchronous active-high reset clears `word_o`, `limit_o` and `rsvd_o`, and sets `rnd_pos_o` to 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_i | input | 56 | Accumulator value, two's complement |
| scale_mode_i | input | 2 | 00 plain, 01 down, 10 up, 11 reserved |
| round_en_i | input | 1 | Round to nearest when high, truncate when low |
| word_o | output | 24 | Scaled, rounded and limited bus word |
| limit_o | output | 1 | Saturation occurred |
| rsvd_o | output | 1 | Reserved mode code seen |
| rnd_pos_o | output | 6 | Rounding bit position for the multiply-accumulate path |

## Verification
The hardest cases sit on the saturation boundary. One is a window that holds exactly 0x7FFFFF and whose lower half-bit is set, so only the rounding carry tips it over. Another is a scale-up input whose bit 46 differs from the sign. Uniformly random 56-bit values almost always saturate and almost never land on these edges. The stimulus therefore draws values whose extension bits are pure sign copies and whose upper window is biased toward the limits. It adds directed values such as 0x007FFFFF800000 and 0x00400000000000 in every mode, with rounding both on and off.

// File: rtl/acc_scale_pkg.sv
package acc_scale_pkg;
  typedef enum logic [1:0] {
    SC_NONE = 2'b00,
    SC_DOWN = 2'b01,
    SC_UP   = 2'b10,
    SC_RSVD = 2'b11
  } scale_e;
endpackage

// File: rtl/scale_decode.sv
module scale_decode
  import acc_scale_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int POS_W  = 6
) (
  input  logic [1:0]       mode_i,
  output logic [POS_W-1:0] pos_o,
  output logic             rsvd_o
);
  localparam logic [POS_W-1:0] POS_NONE = POS_W'(DATA_W - 1);
  localparam logic [POS_W-1:0] POS_DOWN = POS_W'(DATA_W);
  localparam logic [POS_W-1:0] POS_UP   = POS_W'(DATA_W - 2);

  always_comb begin
    rsvd_o = 1'b0;
    unique case (scale_e'(mode_i))
      SC_DOWN: pos_o = POS_DOWN;
      SC_UP:   pos_o = POS_UP;
      SC_RSVD: begin pos_o = POS_NONE; rsvd_o = 1'b1; end
      default: pos_o = POS_NONE;
    endcase
  end
endmodule

// File: rtl/round_add.sv
module round_add #(
  parameter int ACC_W = 56,
  parameter int POS_W = 6
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             en_i,
  output logic [ACC_W:0]   sum_o
);
  logic [ACC_W:0] inc;

  always_comb begin
    inc = '0;
    if (en_i) inc[pos_i] = 1'b1;
    sum_o = {acc_i[ACC_W-1], acc_i} + inc;
  end
endmodule

// File: rtl/sat_limit.sv
module sat_limit #(
  parameter int ACC_W  = 56,
  parameter int DATA_W = 24,
  parameter int POS_W  = 6
) (
  input  logic [ACC_W:0]    sum_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic [DATA_W-1:0] word_o,
  output logic              over_o
);
  localparam logic [DATA_W-1:0] MAX_W = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_W = {1'b1, {(DATA_W-1){1'b0}}};

  logic [POS_W-1:0]        sh;
  logic signed [ACC_W:0]   shifted;
  logic [ACC_W-DATA_W+1:0] top;

  always_comb begin
    sh      = pos_i + 1'b1;
    shifted = $signed(sum_i) >>> sh;
    top     = shifted[ACC_W:DATA_W-1];
    over_o  = !((&top) || !(|top));
    if (over_o) word_o = sum_i[ACC_W] ? MIN_W : MAX_W;
    else        word_o = shifted[DATA_W-1:0];
  end
endmodule

// File: rtl/acc_scaler.sv
module acc_scaler #(
  parameter  int DATA_W = 24,
  parameter  int EXT_W  = 8,
  localparam int ACC_W  = EXT_W + 2 * DATA_W,
  localparam int POS_W  = $clog2(ACC_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [1:0]        scale_mode_i,
  input  logic              round_en_i,
  output logic [DATA_W-1:0] word_o,
  output logic              limit_o,
  output logic              rsvd_o,
  output logic [POS_W-1:0]  rnd_pos_o
);
  localparam logic [POS_W-1:0]  POS_NONE = POS_W'(DATA_W - 1);
  localparam logic [POS_W-1:0]  POS_DOWN = POS_W'(DATA_W);
  localparam logic [POS_W-1:0]  POS_UP   = POS_W'(DATA_W - 2);
  localparam logic [DATA_W-1:0] MAX_W    = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_W    = {1'b1, {(DATA_W-1){1'b0}}};

  logic [POS_W-1:0]  pos_c;
  logic              rsvd_c;
  logic [ACC_W:0]    sum_c;
  logic [DATA_W-1:0] word_c;
  logic              over_c;

  scale_decode #(.DATA_W(DATA_W), .POS_W(POS_W)) u_dec (
    .mode_i (scale_mode_i),
    .pos_o  (pos_c),
    .rsvd_o (rsvd_c)
  );

  round_add #(.ACC_W(ACC_W), .POS_W(POS_W)) u_rnd (
    .acc_i (acc_i),
    .pos_i (pos_c),
    .en_i  (round_en_i),
    .sum_o (sum_c)
  );

  sat_limit #(.ACC_W(ACC_W), .DATA_W(DATA_W), .POS_W(POS_W)) u_lim (
    .sum_i  (sum_c),
    .pos_i  (pos_c),
    .word_o (word_c),
    .over_o (over_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o    <= '0;
      limit_o   <= 1'b0;
      rsvd_o    <= 1'b0;
      rnd_pos_o <= POS_NONE;
    end else begin
      word_o    <= word_c;
      limit_o   <= over_c;
      rsvd_o    <= rsvd_c;
      rnd_pos_o <= pos_c;
    end
  end

  // R6
  limit_value_chk: assert property (@(posedge clk) disable iff (rst)
    limit_o |-> (word_o == MAX_W || word_o == MIN_W));

  // R4
  rsvd_pos_chk: assert property (@(posedge clk) disable iff (rst)
    rsvd_o |-> rnd_pos_o == POS_NONE);

  // R1
  pos_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (rnd_pos_o == POS_NONE || rnd_pos_o == POS_DOWN || rnd_pos_o == POS_UP));

  // R3
  up_pos_chk: assert property (@(posedge clk) disable iff (rst)
    $past(scale_mode_i) == 2'b10 |-> rnd_pos_o == POS_UP);

  // R5
  trunc_plain_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(scale_mode_i) == 2'b00 && !$past(round_en_i) && !limit_o)
      |-> word_o == $past(acc_i[2*DATA_W-1 -: DATA_W]));

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (word_o == '0 && !limit_o && !rsvd_o));
endmodule

// File: tb/acc_scaler_tb.sv
`timescale 1ns/1ps
module acc_scaler_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [55:0] acc = '0;
  logic [1:0]  mode = 2'b00;
  logic        rnd = 1'b0;
  logic [23:0] word;
  logic        lim, rsv;
  logic [5:0]  pos;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  acc_scaler u_dut (
    .clk(clk), .rst(rst), .acc_i(acc), .scale_mode_i(mode),
    .round_en_i(rnd), .word_o(word), .limit_o(lim), .rsvd_o(rsv),
    .rnd_pos_o(pos)
  );

  function automatic int exp_pos(input logic [1:0] m);
    case (m)
      2'b01:   return 24;
      2'b10:   return 22;
      default: return 23;
    endcase
  endfunction

  function automatic logic [24:0] exp_word(input logic [55:0] a,
                                           input logic [1:0] m, input logic r);
    logic signed [63:0] v, q;
    int p;
    p = exp_pos(m);
    v = signed'({{8{a[55]}}, a});
    if (r) v = v + (64'sd1 <<< p);
    q = v >>> (p + 1);
    if (q > 64'sd8388607)  return {1'b1, 24'h7FFFFF};
    if (q < -64'sd8388608) return {1'b1, 24'h800000};
    return {1'b0, q[23:0]};
  endfunction

  task automatic chk(input string req, input string what,
                     input longint act, input longint ex);
    n_chk++;
    if (act != ex) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, ex);
    end
  endtask

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic apply(input logic [55:0] a, input logic [1:0] m, input logic r,
                       input string tag);
    logic [24:0] e;
    @(negedge clk);
    acc = a; mode = m; rnd = r;
    @(posedge clk);
    @(negedge clk);
    e = exp_word(a, m, r);
    chk(tag, "word", longint'(word), longint'(e[23:0]));
    chk(tag, "limit", longint'(lim), longint'(e[24]));
    chk(req_of(m), "rsvd", longint'(rsv), longint'(m == 2'b11));
    chk(req_of(m), "pos", longint'(pos), longint'(exp_pos(m)));
  endtask

  initial begin
    logic [55:0] a;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10", "word", longint'(word), 0);
    chk("R10", "limit", longint'(lim), 0);
    chk("R10", "pos", longint'(pos), 23);
    rst = 1'b0;
    // R1 R2 R3 plain values
    apply(56'h00_123456_789ABC, 2'b00, 1'b0, "R1");
    apply(56'h00_123456_789ABC, 2'b01, 1'b0, "R2");
    apply(56'h00_123456_789ABC, 2'b10, 1'b0, "R3");
    apply(56'h00_123456_789ABC, 2'b11, 1'b1, "R4");
    // R5 truncation vs rounding, negative and half cases
    apply(56'hFF_FFFFFF_FFFFFF, 2'b00, 1'b0, "R5");
    apply(56'hFF_FFFFFF_FFFFFF, 2'b00, 1'b1, "R5");
    apply(56'h00_000001_800000, 2'b00, 1'b1, "R5");
    apply(56'h00_000001_000000, 2'b01, 1'b1, "R5");
    apply(56'h00_000001_400000, 2'b10, 1'b1, "R5");
    // R6 R7 saturation
    apply(56'h01_000000_000000, 2'b00, 1'b0, "R6");
    apply(56'hFE_000000_000000, 2'b00, 1'b0, "R7");
    apply(56'h00_7FFFFF_000000, 2'b00, 1'b1, "R7");
    apply(56'hFF_800000_000000, 2'b00, 1'b0, "R7");
    apply(56'h00_FFFFFF_000000, 2'b01, 1'b0, "R2");
    // R8 left shift sign change
    apply(56'h00_400000_000000, 2'b10, 1'b0, "R8");
    apply(56'hFF_BFFFFF_000000, 2'b10, 1'b0, "R8");
    apply(56'hFF_C00000_000000, 2'b10, 1'b0, "R8");
    apply(56'h00_3FFFFF_800000, 2'b10, 1'b0, "R8");
    // R9 rounding carry overflow
    apply(56'h00_7FFFFF_800000, 2'b00, 1'b1, "R9");
    apply(56'h00_FFFFFF_000000, 2'b01, 1'b1, "R9");
    apply(56'h00_3FFFFF_C00000, 2'b10, 1'b1, "R9");
    apply(56'h00_7FFFFF_800000, 2'b11, 1'b1, "R9");
    // random, biased toward the limit boundaries
    for (int i = 0; i < 600; i++) begin
      a = {$urandom(), $urandom()};
      if ($urandom_range(3) != 0) a[55:47] = {9{a[46]}};
      if ($urandom_range(3) == 0) a[46:30] = a[46] ? 17'h00000 : 17'h1FFFF;
      apply(a, 2'($urandom_range(3)), 1'($urandom_range(1)), "R5");
    end
    // R10 reset again mid-run
    @(negedge clk); rst = 1'b1; acc = 56'h01_000000_000000; mode = 2'b11;
    @(posedge clk); @(negedge clk);
    chk("R10", "word", longint'(word), 0);
    chk("R10", "limit", longint'(lim), 0);
    chk("R10", "rsvd", longint'(rsv), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule